// File: doc/BRIEF.md
# Shared Interrupt Line Aggregator

This block collects level-sensitive interrupt requests from many devices and merges them onto four shared interrupt outputs. Every device owns four request pins. A change on a pin arrives as a single event that names the segment it came from, the device/function number, the pin number and the new level. The block remembers the last level of every pin. Each output line has a reference counter of the asserted sources routed to it, and the line is driven high while its counter is nonzero. The result behaves as a wired OR, but only real level changes do any work.

Two segments are served. Devices on the root segment route straight to the outputs. Devices on the secondary segment sit behind a bridge at slot `BRIDGE_SLOT` of the root segment. Their pin is first rotated by their own slot, then rotated again as though the bridge itself had raised that pin. Routing on each hop is the usual swizzle: the pin number plus the low two bits of the slot, taken modulo four. The slot is bits [7:3] of an 8-bit device/function number. Here it is the bits from 3 upward of a `DEVFN_W`-bit number.

The controller is a four-state machine. `S_IDLE` waits for an event. The transition idle→lookup happens on a handshake. `S_LOOKUP` compares the stored pin level with the new level. The transition lookup→idle drops an event whose level matches the stored level. The transition lookup→count flips the stored level and latches the routed line and the sign of the change. `S_COUNT` applies +1 or −1 to that line's counter, then takes count→drive. `S_DRIVE` registers all four line outputs from their counters. From there it goes drive→lookup if a new event is taken in the same cycle, and drive→idle otherwise.

Top module: `irq_share_hub`

## Requirements
- R1: Events use a valid/ready handshake. `evt_ready` is high only in `S_IDLE` and `S_DRIVE`, so at most one event is taken per clock and `evt_ready` is low in the cycle after any acceptance.
- R2: An event whose level equals the stored level of its pin (stored levels start at 0) changes no stored level, no counter and no output.
- R3: An event with a new level flips that pin's stored level and adds +1 (level 1) or −1 (level 0) to the counter of its routed line. Each segment, device/function number and pin has its own stored level, so two functions of one slot are independent.
- R4: On the root segment (`evt_seg`=0), the routed line is (`evt_pin` + slot) mod 4, where slot is `evt_devfn[DEVFN_W-1:3]`. Line k is `irq_line[k]`.
- R5: On the secondary segment (`evt_seg`=1), the pin is first mapped to q = (`evt_pin` + slot) mod 4, and the routed line is (q + `BRIDGE_SLOT`) mod 4.
- R6: `irq_line[k]` is high exactly when line k's counter is nonzero. The line stays high while any source routed to it is still asserted.
- R7: `irq_line` is registered. A change caused by an event accepted at clock edge n appears after edge n+3, and the outputs change at no other time.
- R8: A synchronous reset clears all counters, all stored pin levels and `irq_line`, and leaves `evt_ready` high.
- R9: A counter is never decremented at zero and never incremented past its maximum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_valid | input | 1 | Event offered |
| evt_ready | output | 1 | Event can be taken this cycle |
| evt_seg | input | 1 | 0 = root segment, 1 = segment behind the bridge |
| evt_devfn | input | DEVFN_W | Device/function number; slot in bits [DEVFN_W-1:3] |
| evt_pin | input | 2 | Pin number 0 to 3 |
| evt_level | input | 1 | New pin level |
| irq_line | output | 4 | Shared interrupt outputs |

## Verification
The two activities that can share a cycle are the output refresh of one event in `S_DRIVE` and the acceptance of the next event. The bench provokes this with bursts of back-to-back events, mixing both segments and raising, lowering and redundant levels, so that each new event is offered the moment `evt_ready` returns. A behavioural model keeps per-pin levels and per-line counts in plain integers. It queues each expected output vector for the third edge after acceptance and compares `irq_line` on every clock, so an update that is lost, or lands a cycle early or late because of the overlap, is reported.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

    localparam int PINS_PER_DEV = 4;
    localparam int NUM_LINES    = 4;
    localparam int LINE_W       = 2;
    localparam int NUM_SEG      = 2;
    localparam int SLOT_LSB     = 3;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_LOOKUP = 2'd1,
        S_COUNT  = 2'd2,
        S_DRIVE  = 2'd3
    } hub_state_e;

    // one routing hop: pin rotated by the low bits of the slot
    function automatic logic [LINE_W-1:0] swizzle(input logic [LINE_W-1:0] pin,
                                                  input logic [LINE_W-1:0] slot_lo);
        return pin + slot_lo;
    endfunction

endpackage

// File: rtl/irq_pin_store.sv
module irq_pin_store
    import irq_hub_pkg::*;
#(
    parameter int DEVFN_W = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               seg,
    input  logic [DEVFN_W-1:0] devfn,
    input  logic [1:0]         pin,
    input  logic               flip,
    output logic               level
);
    localparam int IDX_W   = DEVFN_W + 2;
    localparam int ENTRIES = 1 << IDX_W;

    logic [IDX_W-1:0]   idx;
    logic [NUM_SEG-1:0] seg_bit;

    assign idx = {devfn, pin};

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        logic [ENTRIES-1:0] lvl_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                lvl_q <= '0;
            end else if (flip && (seg == 1'(g))) begin
                lvl_q[idx] <= ~lvl_q[idx];
            end
        end

        assign seg_bit[g] = lvl_q[idx];
    end

    assign level = seg_bit[seg];

    // R3
    level_flip_chk: assert property (@(posedge clk) disable iff (rst)
        flip |=> (level != $past(level)));

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_hub_pkg::*;
#(
    parameter int BRIDGE_SLOT = 1
) (
    input  logic              seg,
    input  logic [1:0]        slot_lo,
    input  logic [1:0]        pin,
    output logic [LINE_W-1:0] line
);
    localparam logic [LINE_W-1:0] BR_OFS = LINE_W'(BRIDGE_SLOT % NUM_LINES);

    logic [LINE_W-1:0] local_pin;

    assign local_pin = swizzle(pin, slot_lo);

    // secondary events continue as if raised by the bridge on the root
    always_comb begin
        if (seg) begin
            line = swizzle(local_pin, BR_OFS);
        end else begin
            line = local_pin;
        end
    end

endmodule

// File: rtl/irq_line_counters.sv
module irq_line_counters
    import irq_hub_pkg::*;
#(
    parameter int MAX_COUNT = 128
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 inc_en,
    input  logic                 dec_en,
    input  logic [LINE_W-1:0]    line,
    output logic [NUM_LINES-1:0] nonzero
);
    localparam int CNT_W = $clog2(MAX_COUNT + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(MAX_COUNT);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic [CNT_W-1:0] cnt_q;
        logic             hit;

        assign hit = (line == LINE_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q <= '0;
            end else if (inc_en && hit) begin
                cnt_q <= cnt_q + 1'b1;
            end else if (dec_en && hit) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end

        assign nonzero[g] = (cnt_q != '0);

        // R9
        no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
            !(dec_en && hit && (cnt_q == '0)));

        // R9
        no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
            !(inc_en && hit && (cnt_q == CNT_TOP)));
    end

endmodule

// File: rtl/irq_share_hub.sv
module irq_share_hub
    import irq_hub_pkg::*;
#(
    parameter int DEVFN_W     = 6,
    parameter int BRIDGE_SLOT = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               evt_valid,
    output logic               evt_ready,
    input  logic               evt_seg,
    input  logic [DEVFN_W-1:0] evt_devfn,
    input  logic [1:0]         evt_pin,
    input  logic               evt_level,
    output logic [3:0]         irq_line
);
    // every pin of every function on both segments could land on one line
    localparam int MAX_COUNT = NUM_SEG * (1 << DEVFN_W);

    hub_state_e st_q, st_d;

    logic               ev_seg_q;
    logic [DEVFN_W-1:0] ev_devfn_q;
    logic [1:0]         ev_pin_q;
    logic               ev_level_q;
    logic [LINE_W-1:0]  line_q;
    logic               up_q;
    logic [3:0]         irq_q;

    logic               accept;
    logic               stored_lvl;
    logic               changed;
    logic               flip;
    logic [LINE_W-1:0]  routed;
    logic [3:0]         line_nz;
    logic               inc_en;
    logic               dec_en;

    assign evt_ready = (st_q == S_IDLE) || (st_q == S_DRIVE);
    assign accept    = evt_valid && evt_ready;
    assign changed   = (stored_lvl != ev_level_q);
    assign flip      = (st_q == S_LOOKUP) && changed;
    assign inc_en    = (st_q == S_COUNT) && up_q;
    assign dec_en    = (st_q == S_COUNT) && !up_q;
    assign irq_line  = irq_q;

    irq_pin_store #(.DEVFN_W(DEVFN_W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .seg   (ev_seg_q),
        .devfn (ev_devfn_q),
        .pin   (ev_pin_q),
        .flip  (flip),
        .level (stored_lvl)
    );

    irq_router #(.BRIDGE_SLOT(BRIDGE_SLOT)) u_route (
        .seg     (ev_seg_q),
        .slot_lo (ev_devfn_q[SLOT_LSB +: 2]),
        .pin     (ev_pin_q),
        .line    (routed)
    );

    irq_line_counters #(.MAX_COUNT(MAX_COUNT)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .inc_en  (inc_en),
        .dec_en  (dec_en),
        .line    (line_q),
        .nonzero (line_nz)
    );

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:   if (accept) st_d = S_LOOKUP;
            S_LOOKUP: st_d = changed ? S_COUNT : S_IDLE;
            S_COUNT:  st_d = S_DRIVE;
            S_DRIVE:  st_d = accept ? S_LOOKUP : S_IDLE;
            default:  st_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= S_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // event capture, routing latch and output register
    always_ff @(posedge clk) begin
        if (rst) begin
            ev_seg_q   <= 1'b0;
            ev_devfn_q <= '0;
            ev_pin_q   <= '0;
            ev_level_q <= 1'b0;
            line_q     <= '0;
            up_q       <= 1'b0;
            irq_q      <= '0;
        end else begin
            if (accept) begin
                ev_seg_q   <= evt_seg;
                ev_devfn_q <= evt_devfn;
                ev_pin_q   <= evt_pin;
                ev_level_q <= evt_level;
            end
            if (st_q == S_LOOKUP) begin
                line_q <= routed;
                up_q   <= ev_level_q;
            end
            if (st_q == S_DRIVE) begin
                irq_q <= line_nz;
            end
        end
    end

    // R1
    one_event_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> !evt_ready);

    // R2
    quiet_drop_chk: assert property (@(posedge clk) disable iff (rst)
        ((st_q == S_LOOKUP) && !changed) |=> $stable(line_nz));

    // R6
    line_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_DRIVE) |=> (irq_line == $past(line_nz)));

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q != S_DRIVE) |=> $stable(irq_line));

endmodule

// File: tb/sim_irq_share_hub.sv
module sim_irq_share_hub;

    localparam int CLK_P   = 10;
    localparam int DEVFN_W = 6;
    localparam int BRIDGE  = 1;
    localparam int NDEV    = 1 << DEVFN_W;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               evt_valid = 1'b0;
    logic               evt_ready;
    logic               evt_seg = 1'b0;
    logic [DEVFN_W-1:0] evt_devfn = '0;
    logic [1:0]         evt_pin = '0;
    logic               evt_level = 1'b0;
    logic [3:0]         irq_line;

    int total = 0;
    int bad   = 0;
    int edge_cnt = 0;
    bit done = 0;

    // behavioural model
    bit       m_lvl [2][NDEV][4];
    int       m_cnt [4];
    logic [3:0] m_exp = '0;
    int         due_q [$];
    logic [3:0] val_q [$];

    irq_share_hub #(.DEVFN_W(DEVFN_W), .BRIDGE_SLOT(BRIDGE)) u0 (
        .clk       (clk),
        .rst       (rst),
        .evt_valid (evt_valid),
        .evt_ready (evt_ready),
        .evt_seg   (evt_seg),
        .evt_devfn (evt_devfn),
        .evt_pin   (evt_pin),
        .evt_level (evt_level),
        .irq_line  (irq_line)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) edge_cnt <= edge_cnt + 1;

    task automatic check4(input string tag, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s irq_line act=%b exp=%b", tag, act, exp);
        end
    endtask

    task automatic check1(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%b exp=%b", tag, act, exp);
        end
    endtask

    // per-clock comparison against queued expectations (R6, R7)
    always @(negedge clk) begin
        if (!rst) begin
            while (due_q.size() > 0 && due_q[0] <= edge_cnt) begin
                m_exp = val_q[0];
                void'(due_q.pop_front());
                void'(val_q.pop_front());
            end
            check4("R7 per-cycle", irq_line, m_exp);
        end
    end

    function automatic int route(input bit seg, input int devfn, input int pin);
        int q;
        q = (pin + (devfn >> 3)) % 4;
        if (seg) q = (q + BRIDGE) % 4;
        return q;
    endfunction

    task automatic send(input bit seg, input int devfn, input int pin, input bit lvl);
        int acc;
        int ln;
        logic [3:0] v;
        @(negedge clk);
        while (!evt_ready) @(negedge clk);
        evt_valid = 1'b1;
        evt_seg   = seg;
        evt_devfn = DEVFN_W'(devfn);
        evt_pin   = 2'(pin);
        evt_level = lvl;
        acc = edge_cnt + 1;
        if (m_lvl[seg][devfn][pin] != lvl) begin
            m_lvl[seg][devfn][pin] = lvl;
            ln = route(seg, devfn, pin);
            m_cnt[ln] += lvl ? 1 : -1;
            for (int k = 0; k < 4; k++) v[k] = (m_cnt[k] != 0);
            due_q.push_back(acc + 3);
            val_q.push_back(v);
        end
        @(negedge clk);
        evt_valid = 1'b0;
        check1("R1 ready low after accept", evt_ready, 1'b0);
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        for (int s = 0; s < 2; s++)
            for (int d = 0; d < NDEV; d++)
                for (int p = 0; p < 4; p++) m_lvl[s][d][p] = 0;
        for (int k = 0; k < 4; k++) m_cnt[k] = 0;
        m_exp = '0;
        due_q.delete();
        val_q.delete();
        repeat (2) @(negedge clk);
        check4("R8 lines cleared", irq_line, 4'b0000);
        check1("R8 ready after reset", evt_ready, 1'b1);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R4: slot 2 pin 1 -> line 3
        send(0, 'h10, 1, 1);
        settle();
        check4("R4 root swizzle", irq_line, 4'b1000);

        // R2: same level again changes nothing
        send(0, 'h10, 1, 1);
        settle();
        check4("R2 redundant raise", irq_line, 4'b1000);

        // R6: two sources on line 3
        send(0, 'h00, 3, 1);
        settle();
        check4("R6 two sources", irq_line, 4'b1000);
        send(0, 'h10, 1, 0);
        settle();
        check4("R6 one source left", irq_line, 4'b1000);
        send(0, 'h00, 3, 0);
        settle();
        check4("R6 all released", irq_line, 4'b0000);

        // R5: secondary slot 1 pin 2 -> q=3 -> line 0
        send(1, 'h08, 2, 1);
        settle();
        check4("R5 bridge route", irq_line, 4'b0001);
        send(0, 'h08, 3, 1);
        send(1, 'h08, 2, 0);
        settle();
        check4("R5 root source holds line", irq_line, 4'b0001);
        send(0, 'h08, 3, 0);
        send(1, 'h08, 2, 0);
        settle();
        check4("R2 redundant lower", irq_line, 4'b0000);

        // R3: two functions of one slot keep separate levels
        send(0, 'h10, 1, 1);
        send(0, 'h11, 1, 1);
        send(0, 'h10, 1, 0);
        settle();
        check4("R3 separate functions", irq_line, 4'b1000);
        send(0, 'h11, 1, 0);
        settle();
        check4("R3 last function lowered", irq_line, 4'b0000);

        // R7: change lands after the third edge
        send(0, 'h00, 0, 1);
        check4("R7 hold edge+1", irq_line, 4'b0000);
        @(negedge clk);
        check4("R7 hold edge+2", irq_line, 4'b0000);
        @(negedge clk);
        check4("R7 hold edge+2b", irq_line, 4'b0000);
        @(negedge clk);
        check4("R7 update edge+3", irq_line, 4'b0001);
        send(0, 'h00, 0, 0);
        settle();

        // back-to-back burst: refresh and next acceptance overlap
        for (int i = 0; i < 60; i++) begin
            send(bit'((i % 3) == 0), (i * 13) % NDEV, i % 4, bit'(((i / 5) % 2) == 0));
        end
        for (int i = 0; i < 30; i++) begin
            send(bit'(i % 2), (i * 7) % NDEV, (i * 3) % 4, bit'(i % 3 != 0));
        end
        settle();

        // R8: mid-run reset clears stored levels too
        send(0, 'h10, 1, 1);
        settle();
        do_reset();
        send(0, 'h10, 1, 0);
        settle();
        check4("R8 stored level cleared", irq_line, 4'b0000);
        send(0, 'h10, 1, 1);
        settle();
        check4("R8 raise after reset", irq_line, 4'b1000);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule